// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of an asynchronous byte-wide flash device. A client hands it one request at a time over a valid/ready handshake: write one byte, erase the whole array, or erase the sector that holds a given address. The sequencer then drives the flash bus (address, write data with its drive enable, and active-low chip, output and write enables) through the unlock and command write cycles that the request needs. Every write cycle is timed in clock cycles, which are derived from a clock-period parameter and from nanosecond limits.

Once the last command byte is written, the sequencer polls the device. It lowers output enable for long enough to cover the status access time, samples bit 6 of the returned byte, raises output enable for a recovery gap, and repeats. While the internal operation runs, bit 6 changes on every read. The operation is complete when two reads in a row agree. A timeout counter, sized above the worst-case erase time, ends a poll that never settles. In both cases the sequencer returns a one-cycle done pulse, with an error flag that marks the timeout case.

Top module: `flash_wr_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `req_ready` is 1, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, and `done` is 0. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. The cycle after a done pulse, the sequencer is idle again.
- R2: Each write cycle has three phases. First comes one cycle with address and data applied and `fl_we_n` high. Then `fl_we_n` is low for exactly WL cycles (WE_LOW_NS rounded up to whole clocks). Then `fl_we_n` is high for exactly WH cycles (WE_HIGH_NS rounded up). Address and data do not change anywhere in these three phases.
- R3: `req_op` = 0 (program byte) issues four write cycles, as (address, data): (0x05555, 0xAA), (0x02AAA, 0x55), (0x05555, 0xA0), (`req_addr`, `req_data`).
- R4: `req_op` = 1 (chip erase) issues six write cycles: (0x05555, 0xAA), (0x02AAA, 0x55), (0x05555, 0x80), (0x05555, 0xAA), (0x02AAA, 0x55), (0x05555, 0x10).
- R5: `req_op` = 2 (sector erase) issues the same first five cycles as R4. The sixth cycle is (`req_addr`, 0x30).
- R6: `fl_ce_n` is low from the first write cycle until polling ends. While `fl_we_n` is low, `fl_oe_n` is high and `fl_dq_oe` is 1. `fl_dq_oe` is 0 whenever `fl_oe_n` is low.
- R7: After the last write cycle the sequencer polls at `req_addr`. `fl_oe_n` is low for RD cycles (OE_ACC_NS rounded up), and `fl_dq_in` is sampled on the edge that ends that window. Then `fl_oe_n` is high for GAP cycles (RD_GAP_NS rounded up), and the read repeats.
- R8: When a sample's bit 6 equals the bit 6 of the previous sample in the same poll, `done` pulses for one cycle with `timeout_err` at 0.
- R9: Let TO be the number of cycles in TIMEOUT_US. If a sample does not settle and at least TO-1 cycles have passed since the first poll cycle, `done` pulses with `timeout_err` at 1. Outside a done pulse, `timeout_err` is 0.
- R10: While a request is in progress, `req_ready` is 0. A `req_valid` raised during that time changes neither the bus sequence nor the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 program byte, 1 chip erase, 2 sector erase |
| req_addr | input | ADDR_W | Byte address or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | High with `done` when polling timed out |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Flash read data (status) |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the block with CLK_PS = 4000 and the default nanosecond limits. This gives 25-cycle write-enable phases and a 9-cycle status window, so every phase length in R2 and R7 is checked at a realistic ratio. It sets TIMEOUT_US = 2 in place of the default 250000. With TO at 500 cycles, a stub that never stops toggling reaches the R9 error path after about fifteen reads. Stub busy times of 0, 150, 200 and 300 cycles cover settling on the first pair of reads as well as settling after many toggles.

// File: rtl/fseq_pkg.sv
// Shared types for the flash program/erase sequencer.
// Assumes the command addresses fit in the low 15 address bits.
package fseq_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_CHIP = 2'd1,
        OP_SECT = 2'd2
    } fseq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_PRD,
        ST_PGAP,
        ST_FIN
    } fseq_state_e;

    localparam logic [14:0] UNLOCK_A = 15'h5555;
    localparam logic [14:0] UNLOCK_B = 15'h2AAA;
endpackage

// File: rtl/fseq_downcnt.sv
// Loadable down counter that stops at zero.
// Assumes load takes priority over counting.
module fseq_downcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Count down from the loaded value and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fseq_steps.sv
// Command table: maps (operation, step) to the bus address and data of
// that write cycle, and flags the final step. Assumes step < 6.
module fseq_steps
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  fseq_op_e          op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_data,
    output logic              last
);
    logic is_prog;
    logic [ADDR_W-1:0] a_unl, b_unl;

    assign is_prog = (op != OP_CHIP) && (op != OP_SECT);
    assign a_unl   = ADDR_W'(UNLOCK_A);
    assign b_unl   = ADDR_W'(UNLOCK_B);

    // Select the cycle contents for the current step.
    always_comb begin
        bus_addr = '0;
        bus_data = 8'h00;
        last     = 1'b0;
        case (step)
            3'd0: begin bus_addr = a_unl; bus_data = 8'hAA; end
            3'd1: begin bus_addr = b_unl; bus_data = 8'h55; end
            3'd2: begin bus_addr = a_unl; bus_data = is_prog ? 8'hA0 : 8'h80; end
            3'd3: begin
                if (is_prog) begin
                    bus_addr = tgt_addr; bus_data = tgt_data; last = 1'b1;
                end else begin
                    bus_addr = a_unl; bus_data = 8'hAA;
                end
            end
            3'd4: begin bus_addr = b_unl; bus_data = 8'h55; end
            3'd5: begin
                last = 1'b1;
                if (op == OP_CHIP) begin bus_addr = a_unl;    bus_data = 8'h10; end
                else               begin bus_addr = tgt_addr; bus_data = 8'h30; end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fseq_toggle.sv
// Toggle-bit settle detector: remembers the previous sampled status bit
// of the current poll and reports when a new sample equals it.
module fseq_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic settled
);
    logic have_q, prev_q;

    // Hold the last sample; forget it when a new poll starts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (sample) begin
            have_q <= 1'b1;
            prev_q <= bit_in;
        end
    end

    assign settled = have_q && (prev_q == bit_in);
endmodule

// File: rtl/flash_wr_seq.sv
// Host-side flash program/erase sequencer. Takes one request, plays the
// write cycles of its command, then polls status bit 6 until two reads
// agree or the timeout expires. Assumes fl_dq_in is synchronous to clk.
module flash_wr_seq
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned CLK_PS     = 4000,
    parameter int unsigned WE_LOW_NS  = 100,
    parameter int unsigned WE_HIGH_NS = 100,
    parameter int unsigned OE_ACC_NS  = 35,
    parameter int unsigned RD_GAP_NS  = 100,
    parameter int unsigned TIMEOUT_US = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              done,
    output logic              timeout_err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    localparam int unsigned WL_RAW  = (WE_LOW_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int unsigned WH_RAW  = (WE_HIGH_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int unsigned RD_RAW  = (OE_ACC_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int unsigned GP_RAW  = (RD_GAP_NS  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int unsigned WL_CYC  = (WL_RAW == 0) ? 1 : WL_RAW;
    localparam int unsigned WH_CYC  = (WH_RAW == 0) ? 1 : WH_RAW;
    localparam int unsigned RD_CYC  = (RD_RAW == 0) ? 1 : RD_RAW;
    localparam int unsigned GAP_CYC = (GP_RAW == 0) ? 1 : GP_RAW;
    localparam int unsigned PH_M1   = (WL_CYC > WH_CYC) ? WL_CYC : WH_CYC;
    localparam int unsigned PH_M2   = (RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC;
    localparam int unsigned PH_MAX  = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
    localparam int unsigned PH_W    = $clog2(PH_MAX + 1);
    localparam logic [63:0] TO_CYC  =
        (64'(TIMEOUT_US) * 64'd1000000 + 64'(CLK_PS) - 64'd1) / 64'(CLK_PS);
    localparam int unsigned TO_W    = $clog2(TO_CYC + 64'd1);

    fseq_state_e       st_q, st_d;
    logic [2:0]        step_q, step_d;
    fseq_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              err_q, err_d, latch;
    logic              ph_load, ph_zero, to_load, to_zero, polling;
    logic [PH_W-1:0]   ph_val;
    logic              tog_clear, tog_sample, settled;
    logic [ADDR_W-1:0] tab_addr;
    logic [7:0]        tab_data;
    logic              tab_last, writing;
    logic              unused_status;

    assign unused_status = ^{fl_dq_in[7], fl_dq_in[5:0]};

    fseq_steps #(.ADDR_W(ADDR_W)) u_steps (
        .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .bus_addr(tab_addr), .bus_data(tab_data), .last(tab_last)
    );

    fseq_downcnt #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
        .en(1'b1), .zero(ph_zero)
    );

    fseq_downcnt #(.W(TO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(to_load),
        .load_val(TO_W'(TO_CYC - 64'd1)), .en(polling), .zero(to_zero)
    );

    fseq_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .clear(tog_clear), .sample(tog_sample),
        .bit_in(fl_dq_in[6]), .settled(settled)
    );

    // Next-state logic: phase sequencing, step advance and poll decisions.
    always_comb begin
        st_d       = st_q;
        step_d     = step_q;
        err_d      = err_q;
        latch      = 1'b0;
        ph_load    = 1'b0;
        ph_val     = '0;
        to_load    = 1'b0;
        tog_clear  = 1'b0;
        tog_sample = 1'b0;
        case (st_q)
            ST_IDLE: if (req_valid) begin
                latch = 1'b1; step_d = '0; err_d = 1'b0;
                st_d = ST_SETUP; ph_load = 1'b1;
            end
            ST_SETUP: begin
                st_d = ST_WLOW; ph_load = 1'b1; ph_val = PH_W'(WL_CYC - 1);
            end
            ST_WLOW: if (ph_zero) begin
                st_d = ST_WHIGH; ph_load = 1'b1; ph_val = PH_W'(WH_CYC - 1);
            end
            ST_WHIGH: if (ph_zero) begin
                ph_load = 1'b1;
                if (tab_last) begin
                    st_d = ST_PRD; ph_val = PH_W'(RD_CYC - 1);
                    to_load = 1'b1; tog_clear = 1'b1;
                end else begin
                    st_d = ST_SETUP; step_d = step_q + 3'd1;
                end
            end
            ST_PRD: if (ph_zero) begin
                tog_sample = 1'b1;
                if (settled) begin
                    st_d = ST_FIN; err_d = 1'b0;
                end else if (to_zero) begin
                    st_d = ST_FIN; err_d = 1'b1;
                end else begin
                    st_d = ST_PGAP; ph_load = 1'b1; ph_val = PH_W'(GAP_CYC - 1);
                end
            end
            ST_PGAP: if (ph_zero) begin
                st_d = ST_PRD; ph_load = 1'b1; ph_val = PH_W'(RD_CYC - 1);
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            err_q  <= err_d;
            if (latch) begin
                op_q   <= fseq_op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    assign writing     = (st_q == ST_SETUP) || (st_q == ST_WLOW) || (st_q == ST_WHIGH);
    assign polling     = (st_q == ST_PRD) || (st_q == ST_PGAP);
    assign req_ready   = (st_q == ST_IDLE);
    assign done        = (st_q == ST_FIN);
    assign timeout_err = (st_q == ST_FIN) && err_q;
    assign fl_ce_n     = (st_q == ST_IDLE) || (st_q == ST_FIN);
    assign fl_we_n     = (st_q != ST_WLOW);
    assign fl_oe_n     = (st_q != ST_PRD);
    assign fl_dq_oe    = writing;
    assign fl_dq_out   = writing ? tab_data : 8'h00;
    assign fl_addr     = writing ? tab_addr : (polling ? addr_q : '0);
endmodule

// File: rtl/fseq_checker.sv
// Property checker for flash_wr_seq, attached by bind. Observes ports
// only; counts write-enable low time to check the pulse width.
module fseq_checker #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned WL_CYC = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              timeout_err,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dq_out,
    input logic              fl_dq_oe,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n
);
    int unsigned low_cnt;

    // Count consecutive cycles with write enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)        low_cnt <= 0;
        else if (!fl_we_n) low_cnt <= low_cnt + 1;
        else               low_cnt <= 0;
    end

    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !done));
    p_ready_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_cnt == WL_CYC));
    p_bus_stable_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
    p_data_hold_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_dq_out) && $stable(fl_addr) && fl_dq_oe));
    p_write_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dq_oe));
    p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n && fl_we_n));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> done);
endmodule

bind flash_wr_seq fseq_checker #(.ADDR_W(ADDR_W), .WL_CYC(WL_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .timeout_err(timeout_err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/sim_flash_wr_seq.sv
// Bench: behavioural flash stub plus a cycle-level reference model
// compared against every output on every clock.
module sim_flash_wr_seq;
    localparam int AW    = 18;
    localparam int T_WL  = 25;   // 100 ns / 4 ns
    localparam int T_WH  = 25;
    localparam int T_RD  = 9;    // 35 ns / 4 ns rounded up
    localparam int T_GAP = 25;
    localparam int T_TO  = 500;  // 2 us / 4 ns

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = 8'h00;
    logic req_ready, done, timeout_err, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dq_out;
    logic [7:0] fl_dq_in = 8'hFF;

    int n_checks = 0, n_errs = 0, cyc = 0;

    always #2 clk = ~clk;

    flash_wr_seq #(.ADDR_W(AW), .CLK_PS(4000), .WE_LOW_NS(100), .WE_HIGH_NS(100),
                   .OE_ACC_NS(35), .RD_GAP_NS(100), .TIMEOUT_US(2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
        .timeout_err(timeout_err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // ---------------- flash stub ----------------
    int stub_len = 0, exp_writes = 4, wr_cnt = 0, busy = 0;
    bit tog = 1'b0, we_p = 1'b1, oe_p = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; we_p = 1'b1; oe_p = 1'b1; tog = 1'b0;
            fl_dq_in <= 8'hFF;
        end else begin
            if (!we_p && fl_we_n && !fl_ce_n) begin
                wr_cnt++;
                if (wr_cnt == exp_writes) busy = stub_len;
            end
            if (oe_p && !fl_oe_n && busy != 0) tog = !tog;
            if (busy > 0) busy--;
            fl_dq_in <= (busy != 0) ? {1'b0, tog, 6'b0} : 8'hFF;
            we_p = fl_we_n;
            oe_p = fl_oe_n;
        end
    end

    // ---------------- reference model ----------------
    // phases: 0 idle, 1 setup, 2 we low, 3 we high, 4 read, 5 gap, 6 finish
    int m_ph = 0, m_left = 0, m_step = 0, m_to = 0;
    bit m_have = 0, m_prev = 0, m_err = 0;
    logic [AW-1:0] m_paddr = '0;
    logic [AW-1:0] qa[$];
    logic [7:0]    qd[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_err = 0; m_paddr = '0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    qa.delete(); qd.delete();
                    qa.push_back(18'h05555); qd.push_back(8'hAA);
                    qa.push_back(18'h02AAA); qd.push_back(8'h55);
                    if (req_op == 2'd0) begin
                        qa.push_back(18'h05555); qd.push_back(8'hA0);
                        qa.push_back(req_addr);  qd.push_back(req_data);
                    end else begin
                        qa.push_back(18'h05555); qd.push_back(8'h80);
                        qa.push_back(18'h05555); qd.push_back(8'hAA);
                        qa.push_back(18'h02AAA); qd.push_back(8'h55);
                        if (req_op == 2'd1) begin qa.push_back(18'h05555); qd.push_back(8'h10); end
                        else                begin qa.push_back(req_addr);  qd.push_back(8'h30); end
                    end
                    m_paddr = req_addr; m_step = 0; m_err = 0; m_ph = 1;
                end
                1: begin m_ph = 2; m_left = T_WL - 1; end
                2: if (m_left == 0) begin m_ph = 3; m_left = T_WH - 1; end else m_left--;
                3: if (m_left == 0) begin
                    if (m_step == qa.size() - 1) begin
                        m_ph = 4; m_left = T_RD - 1; m_to = T_TO - 1; m_have = 0;
                    end else begin
                        m_step++; m_ph = 1;
                    end
                end else m_left--;
                4: begin
                    if (m_left == 0) begin
                        if (m_have && m_prev == fl_dq_in[6]) begin m_ph = 6; m_err = 0; end
                        else if (m_to == 0) begin m_ph = 6; m_err = 1; end
                        else begin m_ph = 5; m_left = T_GAP - 1; end
                        m_have = 1; m_prev = fl_dq_in[6];
                    end else m_left--;
                    if (m_to > 0) m_to--;
                end
                5: begin
                    if (m_left == 0) begin m_ph = 4; m_left = T_RD - 1; end else m_left--;
                    if (m_to > 0) m_to--;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        bit wr;
        logic [AW-1:0] ea;
        logic [7:0] ed;
        wr = (m_ph >= 1 && m_ph <= 3);
        ea = wr ? qa[m_step] : ((m_ph == 4 || m_ph == 5) ? m_paddr : '0);
        ed = wr ? qd[m_step] : 8'h00;
        chk(req_ready == (m_ph == 0), "R1 req_ready", req_ready, m_ph == 0);
        chk(fl_we_n == (m_ph != 2), "R2 fl_we_n", fl_we_n, m_ph != 2);
        chk(fl_addr == ea, "R3 R4 R5 fl_addr", fl_addr, ea);
        chk(fl_dq_out == ed, "R3 R4 R5 fl_dq_out", fl_dq_out, ed);
        chk(fl_ce_n == (m_ph == 0 || m_ph == 6), "R6 fl_ce_n", fl_ce_n, m_ph == 0 || m_ph == 6);
        chk(fl_dq_oe == wr, "R6 fl_dq_oe", fl_dq_oe, wr);
        chk(fl_oe_n == (m_ph != 4), "R7 fl_oe_n", fl_oe_n, m_ph != 4);
        chk(done == (m_ph == 6), "R8 done", done, m_ph == 6);
        chk(timeout_err == (m_ph == 6 && m_err), "R9 timeout_err", timeout_err, m_ph == 6 && m_err);
    end

    // ---------------- stimulus ----------------
    task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int nwr, input int len, input bit exp_err, input bit noise);
        int n;
        exp_writes = nwr; wr_cnt = 0; stub_len = len;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            repeat (40) @(negedge clk);
            req_valid = 1'b1; req_op = 2'd1; req_addr = 18'h00777; req_data = 8'h11;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R8 done seen", done, 1);
        chk(timeout_err == exp_err, exp_err ? "R9 timeout flag" : "R8 clean finish",
            timeout_err, exp_err);
        chk(wr_cnt == nwr, op == 2'd0 ? "R3 write count" : (op == 2'd1 ? "R4 write count"
            : "R5 write count"), wr_cnt, nwr);
        if (noise) chk(wr_cnt == nwr, "R10 no extra writes", wr_cnt, nwr);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && fl_ce_n && fl_oe_n && fl_we_n && !done, "R1 reset state",
            {req_ready, fl_ce_n, fl_oe_n, fl_we_n, done}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(2'd0, 18'h12345, 8'h5A, 4, 200, 1'b0, 1'b0);   // program, settles after toggling
        run(2'd2, 18'h3A123, 8'h00, 6, 300, 1'b0, 1'b1);   // sector erase with ignored request
        run(2'd1, 18'h00040, 8'h00, 6, 150, 1'b0, 1'b0);   // chip erase
        run(2'd0, 18'h3FFFF, 8'h00, 4, 0,   1'b0, 1'b0);   // settles on first pair of reads
        run(2'd2, 18'h00010, 8'h00, 6, -1,  1'b1, 1'b0);   // never settles: timeout
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule